// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Rotate

This block is a purely combinational shifter that conditions the second operand of a data-processing path before it reaches the arithmetic unit. It takes a data word, a shift-kind code, a shift distance and the current carry flag. It returns the shifted word together with a carry-out that logical operations can write into the flag register.

Six shift kinds have defined behaviour: logical left, arithmetic left (which is the same as logical left), logical right, arithmetic right, rotate right, and a single-step rotate right through the carry flag. That last kind treats the carry and the word together as a 33-bit ring. Every kind produces a carry-out. For a zero distance the word passes through unchanged and the carry flag is kept. Internally the left kinds are mirrored onto a single right-shifting core that has log2(W) stages, so all kinds share one shifter.

The block has no clock and no state, so it has no states and no transitions to name. A bench clock is used only to pace the stimulus.

Top module: `shf_barrel`

## Requirements
- R1: Kind code 0 (logical left) with distance n>0 gives value<<n with zero fill, and a carry-out equal to input bit W-n.
- R2: Kind code 1 (arithmetic left) gives exactly the same result and carry-out as kind code 0 for every input.
- R3: Kind code 2 (logical right) with distance n>0 gives value>>n with zero fill, and a carry-out equal to input bit n-1.
- R4: Kind code 3 (arithmetic right) with distance n>0 fills the vacated upper n bits with input bit W-1, and gives a carry-out equal to input bit n-1.
- R5: Kind code 4 (rotate right) with distance n>0 moves the lower n bits into the top of the word, and gives a carry-out equal to bit W-1 of the result.
- R6: Kind code 5 (rotate through carry) outputs {carry_in, value[W-1:1]} with a carry-out equal to value[0]. The distance input has no effect.
- R7: For kind codes 0 to 4, a distance of 0 outputs the input word unchanged, with a carry-out equal to carry_in.
- R8: Kind codes 6 and 7 pass the input word unchanged, with a carry-out equal to carry_in, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_value | input | W (32) | Operand word to be shifted |
| in_kind | input | 3 | Shift kind code (0 to 7, see R1 to R8) |
| in_amount | input | log2(W) (5) | Shift distance |
| in_carry | input | 1 | Current carry flag |
| out_value | output | W (32) | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Every kind code is swept over every distance from 0 to 31 and over both carry values, using eight data words. The word set contains all-zeros and all-ones, single bits at each end, the sign bit alone with its complement, and two irregular patterns. The lone sign bit and its complement make arithmetic-right fill visible apart from logical-right fill. The single end bits expose wrong carry indices and rotate wrap-around. The irregular words catch misrouted stage wiring that symmetric words would hide. Sweeping carry_in at every distance shows that the carry only reaches the result through R6, R7 and R8.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [2:0] {
        SK_LSL   = 3'd0,
        SK_ASL   = 3'd1,
        SK_LSR   = 3'd2,
        SK_ASR   = 3'd3,
        SK_ROR   = 3'd4,
        SK_RRX   = 3'd5,
        SK_RSV6  = 3'd6,
        SK_RSV7  = 3'd7
    } shift_kind_e;

endpackage

// File: rtl/shf_bit_rev.sv
module shf_bit_rev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/shf_right_core.sv
// Logarithmic right shifter: stage s moves the word by 2**s when amount bit s is set.
module shf_right_core #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amount,
    input  logic          rotate,
    input  logic          fill,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [AW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [W-1:0] moved;
        always_comb begin
            if (rotate) begin
                moved = {stage[s][SH-1:0], stage[s][W-1:SH]};
            end else begin
                moved = {{SH{fill}}, stage[s][W-1:SH]};
            end
        end
        assign stage[s+1] = amount[s] ? moved : stage[s];
    end

    assign dout = stage[AW];

endmodule

// File: rtl/shf_carry_pick.sv
// Picks the last bit to leave the word: bit (amount-1) of the right-oriented operand.
module shf_carry_pick #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  oriented,
    input  logic [AW-1:0] amount,
    output logic          picked
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] idx;

    assign idx    = amount - ONE;
    assign picked = oriented[idx];

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  in_value,
    input  logic [2:0]    in_kind,
    input  logic [AW-1:0] in_amount,
    input  logic          in_carry,
    output logic [W-1:0]  out_value,
    output logic          out_carry
);
    import shf_pkg::*;

    shift_kind_e  kind;
    logic         is_left;
    logic         is_shift;
    logic         dist_zero;
    logic         rot_en;
    logic         fill_bit;
    logic [W-1:0] rev_in;
    logic [W-1:0] oriented;
    logic [W-1:0] core_out;
    logic [W-1:0] rev_out;
    logic [W-1:0] shifted;
    logic         last_out;

    assign kind      = shift_kind_e'(in_kind);
    assign dist_zero = (in_amount == '0);

    always_comb begin
        is_left  = 1'b0;
        is_shift = 1'b0;
        rot_en   = 1'b0;
        fill_bit = 1'b0;
        unique case (kind)
            SK_LSL, SK_ASL: begin
                is_left  = 1'b1;
                is_shift = 1'b1;
            end
            SK_LSR: is_shift = 1'b1;
            SK_ASR: begin
                is_shift = 1'b1;
                fill_bit = in_value[W-1];
            end
            SK_ROR: begin
                is_shift = 1'b1;
                rot_en   = 1'b1;
            end
            SK_RRX, SK_RSV6, SK_RSV7: ;
        endcase
    end

    shf_bit_rev #(.W(W)) u_rev_in (
        .din  (in_value),
        .dout (rev_in)
    );

    assign oriented = is_left ? rev_in : in_value;

    shf_right_core #(.W(W), .AW(AW)) u_core (
        .din    (oriented),
        .amount (in_amount),
        .rotate (rot_en),
        .fill   (fill_bit),
        .dout   (core_out)
    );

    shf_bit_rev #(.W(W)) u_rev_out (
        .din  (core_out),
        .dout (rev_out)
    );

    assign shifted = is_left ? rev_out : core_out;

    shf_carry_pick #(.W(W), .AW(AW)) u_pick (
        .oriented (oriented),
        .amount   (in_amount),
        .picked   (last_out)
    );

    always_comb begin
        if (kind == SK_RRX) begin
            out_value = {in_carry, in_value[W-1:1]};
            out_carry = in_value[0];
        end else if (is_shift && !dist_zero) begin
            out_value = shifted;
            out_carry = last_out;
        end else begin
            out_value = in_value;
            out_carry = in_carry;
        end
    end

endmodule

// File: rtl/shf_barrel_chk.sv
module shf_barrel_chk #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input logic [W-1:0]  in_value,
    input logic [2:0]    in_kind,
    input logic [AW-1:0] in_amount,
    input logic          in_carry,
    input logic [W-1:0]  out_value,
    input logic          out_carry
);

    logic nz;
    assign nz = (in_amount != '0);

    always_comb begin
        if (in_kind <= 3'd1 && nz) begin
            a_r1_low_zero_fill: assert (out_value[0] == 1'b0)
                else $error("left shift did not clear bit 0");
        end
        if (in_kind == 3'd2 && nz) begin
            a_r3_top_zero_fill: assert (out_value[W-1] == 1'b0)
                else $error("logical right did not clear top bit");
        end
        if (in_kind == 3'd3) begin
            a_r4_sign_kept: assert (out_value[W-1] == in_value[W-1])
                else $error("arithmetic right lost sign");
        end
        if (in_kind == 3'd4 && nz) begin
            a_r5_ror_carry_top: assert (out_carry == out_value[W-1])
                else $error("rotate carry is not result top bit");
        end
        if (in_kind == 3'd5) begin
            a_r6_rrx_ring: assert (out_value[W-1] == in_carry && out_carry == in_value[0])
                else $error("carry ring broken");
        end
        if (in_kind <= 3'd4 && !nz) begin
            a_r7_zero_pass: assert (out_value == in_value && out_carry == in_carry)
                else $error("zero distance altered operand");
        end
        if (in_kind >= 3'd6) begin
            a_r8_unused_pass: assert (out_value == in_value && out_carry == in_carry)
                else $error("unused code altered operand");
        end
    end

endmodule

bind shf_barrel shf_barrel_chk #(.W(W), .AW(AW)) u_chk (
    .in_value  (in_value),
    .in_kind   (in_kind),
    .in_amount (in_amount),
    .in_carry  (in_carry),
    .out_value (out_value),
    .out_carry (out_carry)
);

// File: tb/shf_barrel_tb.sv
`timescale 1ns/1ps
module shf_barrel_tb;

    localparam int W  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  in_value = '0;
    logic [2:0]    in_kind = '0;
    logic [AW-1:0] in_amount = '0;
    logic          in_carry = 1'b0;
    logic [W-1:0]  out_value;
    logic          out_carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shf_barrel #(.W(W), .AW(AW)) u_dut (
        .in_value  (in_value),
        .in_kind   (in_kind),
        .in_amount (in_amount),
        .in_carry  (in_carry),
        .out_value (out_value),
        .out_carry (out_carry)
    );

    task automatic model(input logic [31:0] v, input int k, input int n, input logic ci,
                         output logic [31:0] r, output logic c);
        r = v;
        c = ci;
        if (k == 5) begin
            r = {ci, v[31:1]};
            c = v[0];
        end else if (k <= 4 && n != 0) begin
            case (k)
                0, 1: begin r = v << n;  c = v[32-n]; end
                2:    begin r = v >> n;  c = v[n-1];  end
                3:    begin r = 32'($signed(v) >>> n); c = v[n-1]; end
                default: begin r = (v >> n) | (v << (32 - n)); c = r[31]; end
            endcase
        end
    endtask

    function automatic string tag_of(input int k, input int n);
        if (k <= 4 && n == 0) return "R7";
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check_pair(input string req, input logic [31:0] ev, input logic ec);
        checks++;
        if (out_value !== ev) begin
            errors++;
            $display("FAIL %s value kind=%0d amt=%0d cin=%0b in=%h actual=%h expected=%h",
                     req, in_kind, in_amount, in_carry, in_value, out_value, ev);
        end
        checks++;
        if (out_carry !== ec) begin
            errors++;
            $display("FAIL %s carry kind=%0d amt=%0d cin=%0b in=%h actual=%0b expected=%0b",
                     req, in_kind, in_amount, in_carry, in_value, out_carry, ec);
        end
    endtask

    initial begin
        logic [31:0] pats [8];
        logic [31:0] ev;
        logic        ec;
        logic [31:0] lsl_v;
        logic        lsl_c;
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000;
        pats[3] = 32'h7FFF_FFFF;
        pats[4] = 32'h0000_0001;
        pats[5] = 32'h8000_0001;
        pats[6] = 32'hA5C3_0F96;
        pats[7] = 32'h1234_5678;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check_pair("R7", 32'h0, 1'b0);  // idle inputs give zero word, carry kept
        rst_n = 1'b1;

        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 8; k++) begin
                for (int n = 0; n < 32; n++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        @(posedge clk);
                        in_value  = pats[p];
                        in_kind   = 3'(k);
                        in_amount = 5'(n);
                        in_carry  = ci[0];
                        @(negedge clk);
                        model(pats[p], k, n, ci[0], ev, ec);
                        check_pair(tag_of(k, n), ev, ec);
                        if (k == 1) begin
                            // R2: arithmetic left must match logical left model
                            model(pats[p], 0, n, ci[0], lsl_v, lsl_c);
                            check_pair("R2", lsl_v, lsl_c);
                        end
                    end
                end
            end
        end

        // R6: distance ignored for the carry ring, same inputs at two distances
        @(posedge clk);
        in_value = 32'h0000_0003; in_kind = 3'd5; in_amount = 5'd0; in_carry = 1'b1;
        @(negedge clk);
        check_pair("R6", 32'h8000_0001, 1'b1);
        @(posedge clk);
        in_amount = 5'd31;
        @(negedge clk);
        check_pair("R6", 32'h8000_0001, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule